// File: doc/BRIEF.md
# Settable 24-hour time-of-day counter

This block keeps the time of day in 24-hour form as hours, minutes and seconds. It runs from a fast system clock and divides that clock internally into a one-cycle enable once per second, which moves the time forward by one second. It presents the time as six registered BCD digits, ready for a display driver or a register read.

Four set inputs move the time forward by one minute, ten minutes, one hour or ten hours. Each set input passes through a two-flop synchronizer and acts only on its rising edge, so the time moves at once and only once per press. It does not wait for the next second. Every change, whether from the second tick, from a set input or from both at once, wraps inside the day. A sum past 23:59:59 folds back into the day, so an hour of 24 or more never appears. A level-sensitive reset clears the time at once, without a clock edge.

Top module: `tod_counter`

## Requirements
- R1: While `rst` is high all six digits read 0, and they clear as soon as `rst` rises, with no clock edge needed.
- R2: With no set activity, the time advances by exactly one second on every TICK_DIV-th rising clock edge after reset is released, starting with edge number TICK_DIV, and it holds steady in between.
- R3: The seconds carry into the minutes and the minutes carry into the hours. After 23:59:59 the next second gives 00:00:00.
- R4: Set bits add fixed amounts: bit 0 adds 60 s, bit 1 adds 600 s, bit 2 adds 3600 s and bit 3 adds 36000 s. The time changes on the third rising edge after the bit rises, which is two synchronizer stages and then one edge-detect cycle.
- R5: When several set bits rise in the same cycle, only the lowest-numbered one acts. The rising edges of the other bits are discarded.
- R6: A set bit that is held high advances the time only once. It must fall and rise again before it acts again.
- R7: Setting adds modulo 86400 s. The seconds and the minutes not covered by the step are kept, and the hours never reach 24.
- R8: When a second tick and a set edge fall on the same cycle, both are applied. The time advances by 1 s plus the set amount, modulo 86400 s.
- R9: The outputs are BCD, and each digit is 0 to 9. The tens of seconds and the tens of minutes stay at 5 or below, and the tens of hours stay at 2 or below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset to 00:00:00 |
| set_btn | input | 4 | Set requests: bit0 +1 min, bit1 +10 min, bit2 +1 h, bit3 +10 h |
| sec_ones | output | 4 | Seconds units digit (BCD) |
| sec_tens | output | 4 | Seconds tens digit (BCD) |
| min_ones | output | 4 | Minutes units digit (BCD) |
| min_tens | output | 4 | Minutes tens digit (BCD) |
| hr_ones | output | 4 | Hours units digit (BCD) |
| hr_tens | output | 4 | Hours tens digit (BCD) |

## Verification
The bench uses a divider of four cycles, so seconds pass quickly. It compares the digits on every cycle against a seconds-of-day count that it keeps arithmetically.

The stimulus falls into several groups:
- **Free running:** separates the second tick from the set path.
- **Repeated single-step presses:** walk every hour and minute value across their wrap points and catch wrong step sizes and wrap limits.
- **Simultaneous multi-bit presses:** show whether the lowest-numbered bit wins.
- **A long hold:** catches level rather than edge detection.
- **Presses at each phase of the divider:** force a set edge onto the tick cycle.
- **A climb to 23:59 followed by free running:** exercises the full carry chain into midnight.

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int unsigned TICK_DIV    = 50_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] set_btn,
  output logic [3:0] sec_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [3:0] min_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] hr_tens
);

  localparam int unsigned DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  function automatic logic [7:0] to_bcd(input logic [5:0] v);
    logic [5:0] t;
    t = v / 6'd10;
    return {t[3:0], 4'(v - t * 6'd10)};
  endfunction

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] prev_q;
  logic [3:0] rise;
  logic [3:0] grant;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= set_btn;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise  = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign grant = rise & (~rise + 4'd1);

  logic [3:0] add_min;
  logic [3:0] add_hr;

  assign add_min = grant[0] ? 4'd1 : (grant[1] ? 4'd10 : 4'd0);
  assign add_hr  = grant[2] ? 4'd1 : (grant[3] ? 4'd10 : 4'd0);

  logic [5:0] ss_q, mm_q;
  logic [4:0] hh_q;
  logic [6:0] s_sum, m_sum;
  logic [5:0] h_sum;
  logic       s_wrap, m_wrap, h_wrap;
  logic [5:0] s_nxt, m_nxt;
  logic [4:0] h_nxt;

  assign s_sum  = {1'b0, ss_q} + {6'd0, tick};
  assign s_wrap = (s_sum >= 7'd60);
  assign s_nxt  = s_wrap ? 6'(s_sum - 7'd60) : s_sum[5:0];

  assign m_sum  = {1'b0, mm_q} + {6'd0, s_wrap} + {3'd0, add_min};
  assign m_wrap = (m_sum >= 7'd60);
  assign m_nxt  = m_wrap ? 6'(m_sum - 7'd60) : m_sum[5:0];

  assign h_sum  = {1'b0, hh_q} + {5'd0, m_wrap} + {2'd0, add_hr};
  assign h_wrap = (h_sum >= 6'd24);
  assign h_nxt  = h_wrap ? 5'(h_sum - 6'd24) : h_sum[4:0];

  logic [7:0] s_bcd, m_bcd, h_bcd;

  assign s_bcd = to_bcd(s_nxt);
  assign m_bcd = to_bcd(m_nxt);
  assign h_bcd = to_bcd({1'b0, h_nxt});

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ss_q <= '0;
      mm_q <= '0;
      hh_q <= '0;
      {sec_tens, sec_ones} <= '0;
      {min_tens, min_ones} <= '0;
      {hr_tens,  hr_ones}  <= '0;
    end else begin
      ss_q <= s_nxt;
      mm_q <= m_nxt;
      hh_q <= h_nxt;
      {sec_tens, sec_ones} <= s_bcd;
      {min_tens, min_ones} <= m_bcd;
      {hr_tens,  hr_ones}  <= h_bcd;
    end
  end

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [3:0] rise,
  input logic [3:0] grant,
  input logic [3:0] sec_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] min_ones,
  input logic [3:0] min_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] hr_tens
);

  int unsigned cyc_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                        cyc_q <= 0;
    else if (cyc_q == TICK_DIV - 1) cyc_q <= 0;
    else                            cyc_q <= cyc_q + 1;
  end

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst)
    tick == (cyc_q == TICK_DIV - 1)); // R2

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && grant == 4'd0) |=>
      $stable({sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens})); // R2

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R5

  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
    (rise != 4'd0) |=> ((rise & $past(rise)) == 4'd0)); // R6

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    sec_ones <= 4'd9 && min_ones <= 4'd9 && hr_ones <= 4'd9 &&
    sec_tens <= 4'd5 && min_tens <= 4'd5 && hr_tens <= 4'd2); // R9

  AST_HOUR_BELOW_24: assert property (@(posedge clk) disable iff (rst)
    !(hr_tens == 4'd2 && hr_ones > 4'd3)); // R7

  always @(negedge clk) begin
    if (rst) begin
      AST_RESET_ZERO: assert ({sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens} == 24'd0); // R1
    end
  end

endmodule

bind tod_counter tod_counter_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .rise(rise), .grant(grant),
  .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
  .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] btn;
  logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string phase  = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_counter #(.TICK_DIV(DIV), .SYNC_STAGES(2)) i_tod_counter (
    .clk(clk), .rst(rst), .set_btn(btn),
    .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones),
    .min_tens(min_tens), .hr_ones(hr_ones), .hr_tens(hr_tens)
  );

  int         m_div;
  logic [3:0] b1, b2, b3;
  int         exp_t;

  always @(posedge clk or posedge rst) begin
    int         amt;
    logic [3:0] r;
    bit         tk;
    if (rst) begin
      m_div <= 0; b1 <= 0; b2 <= 0; b3 <= 0; exp_t <= 0;
    end else begin
      r   = b2 & ~b3;
      amt = r[0] ? 60 : r[1] ? 600 : r[2] ? 3600 : r[3] ? 36000 : 0;
      tk  = (m_div == DIV - 1);
      m_div <= tk ? 0 : m_div + 1;
      b1 <= btn; b2 <= b1; b3 <= b2;
      exp_t <= (exp_t + (tk ? 1 : 0) + amt) % 86400;
    end
  end

  task automatic check_time(input string tag, input int t);
    int h, m, s;
    h = t / 3600; m = (t / 60) % 60; s = t % 60;
    checks++;
    if (hr_tens != 4'(h/10) || hr_ones != 4'(h%10) || min_tens != 4'(m/10) ||
        min_ones != 4'(m%10) || sec_tens != 4'(s/10) || sec_ones != 4'(s%10)) begin
      errors++;
      $display("FAIL %s: got %0d%0d:%0d%0d:%0d%0d expected %0d%0d:%0d%0d:%0d%0d", tag,
               hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones,
               h/10, h%10, m/10, m%10, s/10, s%10);
    end
  endtask

  always @(negedge clk) if (!rst && !done) check_time(phase, exp_t);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] mask);
    btn = mask; step(4); btn = 4'd0; step(4);
  endtask

  initial begin
    rst = 1'b1; btn = 4'd0;
    #1 check_time("R1 reset at time zero", 0);
    step(3);
    check_time("R1 reset held", 0);
    rst = 1'b0;

    phase = "R2 free-running seconds";
    step(DIV - 1);
    check_time("R2 no advance before edge TICK_DIV", 0);
    step(1);
    check_time("R2 first second at edge TICK_DIV", 1);
    phase = "R3 seconds into minutes";
    step(DIV * 70);

    phase = "R4 R7 one-hour steps wrap";
    for (int i = 0; i < 30; i++) press(4'b0100);
    phase = "R4 R7 ten-hour steps wrap";
    for (int i = 0; i < 5; i++) press(4'b1000);
    phase = "R4 R7 ten-minute steps";
    for (int i = 0; i < 8; i++) press(4'b0010);
    phase = "R4 R7 one-minute steps";
    for (int i = 0; i < 65; i++) press(4'b0001);

    phase = "R5 simultaneous set bits";
    press(4'b1111);
    press(4'b1100);
    press(4'b1010);
    press(4'b0110);

    phase = "R6 held set bit";
    btn = 4'b0100; step(40); btn = 4'd0; step(4);
    press(4'b0100);

    phase = "R8 set edge against every tick phase";
    for (int i = 0; i < 2 * DIV; i++) begin
      step(i % DIV);
      press(4'b0001);
    end

    @(posedge clk); #(CLK_PERIOD/4) rst = 1'b1;
    #1 check_time("R1 asynchronous clear", 0);
    step(2); rst = 1'b0;

    phase = "R3 climb to 23:59";
    press(4'b1000); press(4'b1000);
    for (int i = 0; i < 3; i++) press(4'b0100);
    for (int i = 0; i < 5; i++) press(4'b0010);
    for (int i = 0; i < 9; i++) press(4'b0001);
    phase = "R3 R9 midnight rollover";
    step(DIV * 75);
    phase = "R7 ten-hour step from late evening";
    for (int i = 0; i < 14; i++) press(4'b0100);
    press(4'b1000);
    step(DIV);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule